// File: doc/BRIEF.md
# Serial Flash Register-Read Responder

This block is the target-side logic of a serial flash device that answers the single-byte register-read commands on a SPI mode 0 bus. While chip select is low, the host sends an 8-bit command byte on the serial input. If the byte names one of three registers, the block drives that register on the serial output, most significant bit first. It keeps sending the register again, byte after byte, for as long as the host keeps clocking.

The three registers are second status, configuration and bank address. Each arrives as a parallel input. A fresh copy of the selected register is taken at every byte boundary, so a status change made by the device's internal engines shows up in the next byte the host reads. A busy indication from those engines never holds back the answer. The output-enable models the high-impedance state of the serial output pin.

Top module: `spi_regrd_resp`

## Requirements
- R1: Command byte 0x07 selects the second status register (`stat2_i`) for output.
- R2: Command byte 0x35 selects the configuration register (`cfg_i`) for output.
- R3: Command byte 0x16 selects the bank address register (`bank_i`) for output.
- R4: The command is taken from `si_i` on the first eight rising SCK edges after chip select falls, most significant bit first. `oe_o` stays 0 through all eight of those edges.
- R5: `so_o` and `oe_o` change only on falling SCK edges. The first register bit, bit 7, is driven, with `oe_o` = 1, on the falling edge that follows the eighth rising edge.
- R6: Each output byte is sent most significant bit first. While clocking continues, the selected register is sent again every eight cycles with no gap.
- R7: The register value is sampled at the falling edge that starts each output byte. A change to the input in the middle of a byte does not alter that byte, and it appears in the next byte.
- R8: `busy_i` has no effect on the response. A valid command is answered in the same way whether `busy_i` is 0 or 1.
- R9: Chip select high forces `oe_o` to 0 at once, clears the bit counters and aborts the transaction. The next transaction starts cleanly.
- R10: Any other command byte keeps `oe_o` at 0 for as long as chip select stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Chip select, active low; when high it acts as an asynchronous clear |
| si_i | input | 1 | Serial data from the host |
| busy_i | input | 1 | Internal program or erase busy indication (ignored) |
| stat2_i | input | 8 | Second status register value |
| cfg_i | input | 8 | Configuration register value |
| bank_i | input | 8 | Bank address register value |
| so_o | output | 1 | Serial data to the host |
| oe_o | output | 1 | Output enable; 0 means SO is high impedance |

## Verification
Each of the three valid commands is sent, with values in the registers that differ from one another. This shows that the right register is selected and that bits come out most significant bit first. Runs of three bytes, with the register input changed partway through a byte, separate a design that samples at the byte boundary from one that samples once per transaction or passes the input straight through. A run with busy asserted shows that busy has no effect. An unknown command, an abort in the middle of the command byte and an abort in the middle of the data show that output stays disabled and that the counters restart.

// File: rtl/spi_regrd_pkg.sv
package spi_regrd_pkg;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_STAT2 = 2'd1,
      SEL_CFG   = 2'd2,
      SEL_BANK  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/srr_opcode_rx.sv
module srr_opcode_rx #(
   parameter int OP_W = 8
) (
   input  logic            sck_i,
   input  logic            cs_n_i,
   input  logic            si_i,
   output logic            op_done_o,
   output logic [OP_W-1:0] op_o
);
   localparam int CW = (OP_W > 1) ? $clog2(OP_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(OP_W - 1);

   logic [CW-1:0]   bit_cnt;
   logic [OP_W-1:0] op_q;
   logic            done_q;

   generate
      if (OP_W < 2) begin : g_bad_opw
         $error("srr_opcode_rx: OP_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge sck_i or posedge cs_n_i) begin
      if (cs_n_i) begin
         bit_cnt <= '0;
         op_q    <= '0;
         done_q  <= 1'b0;
      end else if (!done_q) begin
         op_q <= {op_q[OP_W-2:0], si_i};
         if (bit_cnt == LAST) begin
            done_q <= 1'b1;
         end else begin
            bit_cnt <= bit_cnt + CW'(1);
         end
      end
   end

   assign op_done_o = done_q;
   assign op_o      = op_q;

endmodule

// File: rtl/srr_decode.sv
module srr_decode
   import spi_regrd_pkg::*;
#(
   parameter int              OP_W     = 8,
   parameter logic [OP_W-1:0] OP_STAT2 = 8'h07,
   parameter logic [OP_W-1:0] OP_CFG   = 8'h35,
   parameter logic [OP_W-1:0] OP_BANK  = 8'h16
) (
   input  logic            op_done_i,
   input  logic [OP_W-1:0] op_i,
   output reg_sel_e        sel_o,
   output logic            hit_o
);

   generate
      if (OP_STAT2 == OP_CFG || OP_STAT2 == OP_BANK || OP_CFG == OP_BANK) begin : g_bad_ops
         $error("srr_decode: command codes must be distinct");
      end
   endgenerate

   always_comb begin
      sel_o = SEL_NONE;
      if (op_done_i) begin
         unique case (op_i)
            OP_STAT2: sel_o = SEL_STAT2;
            OP_CFG:   sel_o = SEL_CFG;
            OP_BANK:  sel_o = SEL_BANK;
            default:  sel_o = SEL_NONE;
         endcase
      end
   end

   assign hit_o = (sel_o != SEL_NONE);

endmodule

// File: rtl/srr_tx.sv
module srr_tx #(
   parameter int REG_W = 8
) (
   input  logic             sck_i,
   input  logic             cs_n_i,
   input  logic             start_i,
   input  logic             fresh_i,
   input  logic [REG_W-1:0] data_i,
   output logic             so_o,
   output logic             oe_o
);
   localparam int CW = (REG_W > 1) ? $clog2(REG_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(REG_W - 1);

   logic [CW-1:0]    cnt_q;
   logic [REG_W-1:0] sh_q;
   logic [REG_W-1:0] hold_q;
   logic             oe_q;
   logic             take_new;

   generate
      if (REG_W < 2) begin : g_bad_regw
         $error("srr_tx: REG_W must be at least 2");
      end
   endgenerate

   // first byte of a transaction always samples the input
   assign take_new = fresh_i || !oe_q;

   always_ff @(negedge sck_i or posedge cs_n_i) begin
      if (cs_n_i) begin
         cnt_q  <= '0;
         sh_q   <= '0;
         hold_q <= '0;
         oe_q   <= 1'b0;
      end else if (start_i) begin
         oe_q <= 1'b1;
         if (cnt_q == '0) begin
            sh_q <= take_new ? data_i : hold_q;
            if (take_new) hold_q <= data_i;
         end else begin
            sh_q <= {sh_q[REG_W-2:0], 1'b0};
         end
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      end
   end

   assign so_o = sh_q[REG_W-1];
   assign oe_o = oe_q;

   // R7: a byte boundary that samples puts the input's top bit on SO
   a_r7_boundary_sample: assert property (@(negedge sck_i) disable iff (cs_n_i)
      (start_i && cnt_q == '0 && take_new) |=> (so_o == $past(data_i[REG_W-1])));

   // R6: after the last bit of a byte the next byte begins at once
   a_r6_byte_wrap: assert property (@(negedge sck_i) disable iff (cs_n_i)
      (start_i && oe_q && cnt_q == LAST) |=> (oe_o && cnt_q == '0));

endmodule

// File: rtl/spi_regrd_resp.sv
module spi_regrd_resp
   import spi_regrd_pkg::*;
#(
   parameter int               OP_W       = 8,
   parameter int               REG_W      = 8,
   parameter logic [OP_W-1:0]  OP_STAT2   = 8'h07,
   parameter logic [OP_W-1:0]  OP_CFG     = 8'h35,
   parameter logic [OP_W-1:0]  OP_BANK    = 8'h16,
   parameter bit               RELOAD_ALL = 1'b1
) (
   input  logic             sck_i,
   input  logic             cs_n_i,
   input  logic             si_i,
   input  logic             busy_i,
   input  logic [REG_W-1:0] stat2_i,
   input  logic [REG_W-1:0] cfg_i,
   input  logic [REG_W-1:0] bank_i,
   output logic             so_o,
   output logic             oe_o
);

   logic             op_done;
   logic [OP_W-1:0]  op_code;
   reg_sel_e         sel;
   logic             hit;
   logic [REG_W-1:0] reg_val;
   logic             fresh;

   srr_opcode_rx #(.OP_W(OP_W)) u_rx (
      .sck_i     (sck_i),
      .cs_n_i    (cs_n_i),
      .si_i      (si_i),
      .op_done_o (op_done),
      .op_o      (op_code)
   );

   srr_decode #(
      .OP_W     (OP_W),
      .OP_STAT2 (OP_STAT2),
      .OP_CFG   (OP_CFG),
      .OP_BANK  (OP_BANK)
   ) u_dec (
      .op_done_i (op_done),
      .op_i      (op_code),
      .sel_o     (sel),
      .hit_o     (hit)
   );

   always_comb begin
      unique case (sel)
         SEL_STAT2: reg_val = stat2_i;
         SEL_CFG:   reg_val = cfg_i;
         SEL_BANK:  reg_val = bank_i;
         default:   reg_val = '0;
      endcase
   end

   generate
      if (RELOAD_ALL) begin : g_reload_all
         assign fresh = 1'b1;
      end else begin : g_reload_status
         assign fresh = (sel == SEL_STAT2);
      end
   endgenerate

   srr_tx #(.REG_W(REG_W)) u_tx (
      .sck_i   (sck_i),
      .cs_n_i  (cs_n_i),
      .start_i (hit),
      .fresh_i (fresh),
      .data_i  (reg_val),
      .so_o    (so_o),
      .oe_o    (oe_o)
   );

   // R4: no drive while the command byte is still arriving
   a_r4_quiet_opcode: assert property (@(posedge sck_i) disable iff (cs_n_i)
      !op_done |-> !oe_o);

   // R10: an unknown command never enables the output
   a_r10_unknown_silent: assert property (@(posedge sck_i) disable iff (cs_n_i)
      (op_done && !hit) |-> !oe_o);

   // R8: a decoded command is answered even while busy is high
   a_r8_busy_ignored: assert property (@(negedge sck_i) disable iff (cs_n_i)
      (busy_i && hit) |=> oe_o);

endmodule

// File: tb/tb_spi_regrd_resp.sv
module tb_spi_regrd_resp;

   logic       sck = 1'b0;
   logic       cs_n = 1'b1;
   logic       si = 1'b0;
   logic       busy = 1'b0;
   logic [7:0] stat2 = 8'h00;
   logic [7:0] cfg = 8'h00;
   logic [7:0] bank = 8'h00;
   logic       so;
   logic       oe;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   always #2 sck = ~sck;   // 250 MHz

   spi_regrd_resp dut (
      .sck_i (sck), .cs_n_i (cs_n), .si_i (si), .busy_i (busy),
      .stat2_i (stat2), .cfg_i (cfg), .bank_i (bank),
      .so_o (so), .oe_o (oe)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge sck) begin
      cycles++;
      if (cycles > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected below 100000", cycles);
         finish_run();
      end
   end

   // drive command byte; oe must stay low (R4); first bit at following fall (R5)
   task automatic send_op(input logic [7:0] op);
      for (int i = 7; i >= 0; i--) begin
         @(negedge sck); #1;
         cs_n = 1'b0;
         si = op[i];
         chk("R4 oe during command", oe, 0);
      end
      @(posedge sck); #1;
      chk("R5 oe after 8th rise", oe, 0);
   endtask

   // read one byte; optionally change a register after bit mid_bit
   task automatic read_byte(input string req, input logic [7:0] exp,
                            input int mid_bit, input int which, input logic [7:0] nv);
      logic [7:0] got;
      int oe_ok;
      got = '0; oe_ok = 1;
      for (int k = 7; k >= 0; k--) begin
         @(negedge sck); #1;
         got[k] = so;
         if (oe !== 1'b1) oe_ok = 0;
         if (k == mid_bit) begin
            if (which == 1) stat2 = nv;
            if (which == 2) cfg = nv;
            if (which == 3) bank = nv;
         end
      end
      chk({req, " oe"}, oe_ok, 1);
      chk(req, got, exp);
   endtask

   task automatic end_txn();
      @(negedge sck); #1;
      cs_n = 1'b1;
      #0.5;
      chk("R9 oe after cs high", oe, 0);
   endtask

   task automatic t_reset();
      @(negedge sck); #1;
      chk("R9 idle oe", oe, 0);
   endtask

   task automatic t_stat2_busy();
      stat2 = 8'hA3; busy = 1'b1;
      send_op(8'h07);
      read_byte("R1 R8 stat2 byte0", 8'hA3, 4, 1, 8'h5C);   // R7 mid-byte change
      read_byte("R7 stat2 byte1 new", 8'h5C, 0, 1, 8'h81);
      read_byte("R6 stat2 byte2", 8'h81, -1, 0, 8'h00);
      end_txn();
      busy = 1'b0;
   endtask

   task automatic t_cfg();
      cfg = 8'h6E; stat2 = 8'h11; bank = 8'h22;
      send_op(8'h35);
      read_byte("R2 cfg byte0", 8'h6E, -1, 0, 8'h00);
      read_byte("R6 cfg byte1 repeat", 8'h6E, 2, 2, 8'hC1);
      read_byte("R7 cfg byte2 new", 8'hC1, -1, 0, 8'h00);
      end_txn();
   endtask

   task automatic t_bank();
      bank = 8'h01; cfg = 8'hFF; stat2 = 8'hFF;
      send_op(8'h16);
      read_byte("R3 bank byte0", 8'h01, 6, 3, 8'h80);
      read_byte("R7 bank byte1", 8'h80, -1, 0, 8'h00);
      end_txn();
   endtask

   task automatic t_unknown();
      int seen;
      seen = 0;
      send_op(8'hA5);
      for (int k = 0; k < 16; k++) begin
         @(negedge sck); #1;
         if (oe !== 1'b0) seen = 1;
      end
      chk("R10 unknown command oe", seen, 0);
      end_txn();
   endtask

   task automatic t_abort();
      // abort in the middle of the command byte
      for (int i = 7; i >= 4; i--) begin
         @(negedge sck); #1; cs_n = 1'b0; si = 1'b1;
      end
      end_txn();
      stat2 = 8'h3C;
      send_op(8'h07);
      read_byte("R9 after command abort", 8'h3C, -1, 0, 8'h00);
      // abort in the middle of a data byte
      for (int k = 0; k < 3; k++) begin
         @(negedge sck); #1;
      end
      end_txn();
      bank = 8'h9D;
      send_op(8'h16);
      read_byte("R9 after data abort", 8'h9D, -1, 0, 8'h00);
      end_txn();
   endtask

   initial begin
      t_reset();
      t_stat2_busy();
      t_cfg();
      t_bank();
      t_unknown();
      t_abort();
      repeat (2) @(negedge sck);
      finish_run();
   end

endmodule